// File: doc/BRIEF.md
# Match-Compare Timer

This block is a register-mapped up-counter for event scheduling. It has one prescaler and one compare channel. The prescaler divides the core clock by a programmable amount. Each prescaled tick advances the count. When the count equals the programmed compare value on a tick, three independent actions can follow, each enabled by its own bit: raise a pending flag, return the count to zero, or halt counting. Software clears the pending flag by writing a one to it. The interrupt line shows the state of that flag.

A small state machine owns the two control bits (enable and hold-in-reset) and has four named states:

| State | Meaning |
|-------|---------|
| ST_IDLE | Disabled, not held |
| ST_RUN | Enabled and counting |
| ST_HOLD_IDLE | Held in reset with enable clear |
| ST_HOLD_RUN | Held in reset with enable set |

The state encoding is `{hold, enable}`, so the control register reads back the state code directly. It has three transitions:
- **write**: any write to the control register moves the machine to the state whose code is the written bits [1:0].
- **match-stop**: in ST_RUN, a compare hit with halting enabled moves the machine to ST_IDLE.
- **stay**: every other cycle keeps the current state.

Typical uses:
- **Periodic tick**: enable pending and count-reset; a compare value N then gives one event every N+1 ticks.
- **One-shot**: also enable halting; after the single event, software re-arms the timer by setting the enable bit again.
- **Free-running time base**: clear all three action bits; the count simply runs and wraps.

The bus is a simple synchronous register port. Writes take effect at the rising clock edge when `we_i` is high. `rdata_o` is a combinational decode of `addr_i`.

Top module: `mct_timer`

## Requirements
- R1: After reset every register reads 0, the state is ST_IDLE and `irq_o` is low.
- R2: With prescale value P at offset 0x00C, the count advances once every P+1 clocks while in ST_RUN.
- R3: With action bits all zero, a compare hit has no effect, and the count (offset 0x008) runs freely and wraps from all ones to zero at the counter width.
- R4: When the pending action (bit 0 of the action register at 0x014) is set, a compare hit sets bit 0 of the status register at 0x000, and `irq_o` follows that bit.
- R5: When the count-reset action (bit 1 at 0x014) is set, the count after a hit is zero. A compare value N therefore gives a period of N+1 ticks.
- R6: When the halt action (bit 2 at 0x014) is set, a hit clears the enable bit (bit 0 of control at 0x004). The count then holds the compare value, or zero if count-reset is also set. Writing enable again restarts counting.
- R7: While hold (bit 1 of control) is set, the count and the prescale counter are kept at zero, whatever the enable bit is.
- R8: Writing 1 to status bit 0 clears the pending flag. Writing 0 leaves it unchanged. If a hit and a clear happen in the same cycle, the hit wins.
- R9: Writes to the count register (0x008) and to the mode register (0x070) are ignored. The mode register always reads 0.
- R10: Prescale (0x00C), action (0x014, 3 bits) and compare (0x018) read back what was written. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte offset of the register |
| we_i | input | 1 | Write strobe |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for `addr_i` |
| irq_o | output | 1 | Pending compare event |

## Verification
The hardest case to reach is a hit that coincides with a decision edge: the count-reset and halt actions on the very tick of the match, and the restart after a halt. The stimulus reaches these by first holding the counter in reset, so that the count starts from a known zero. It then programs small compare and prescale values and waits a computed number of clocks, so the bench knows exactly which tick produced the hit. Wrap-around cannot be reached at 32 bits, so a second instance with an 8-bit counter shares the same bus and shows the roll-over.

// File: rtl/mct_pkg.sv
package mct_pkg;

    // Register byte offsets
    localparam int unsigned OFS_STAT = 32'h000;
    localparam int unsigned OFS_CTL  = 32'h004;
    localparam int unsigned OFS_CNT  = 32'h008;
    localparam int unsigned OFS_PRE  = 32'h00C;
    localparam int unsigned OFS_ACT  = 32'h014;
    localparam int unsigned OFS_CMP  = 32'h018;
    localparam int unsigned OFS_MODE = 32'h070;

    // Encoding is {hold, enable} so the control register reads the state
    typedef enum logic [1:0] {
        ST_IDLE      = 2'b00,
        ST_RUN       = 2'b01,
        ST_HOLD_IDLE = 2'b10,
        ST_HOLD_RUN  = 2'b11
    } tmr_state_e;

    // Match actions: bit 0 pending, bit 1 count reset, bit 2 halt
    typedef struct packed {
        logic halt;
        logic reload;
        logic pend;
    } match_act_t;

endpackage

// File: rtl/mct_ctrl_fsm.sv
module mct_ctrl_fsm
    import mct_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       ctl_we_i,
    input  logic [1:0] ctl_wdata_i,
    input  logic       stop_req_i,
    output tmr_state_e state_o,
    output logic       run_o,
    output logic       hold_o
);

    tmr_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      state_d = ST_IDLE;
            ST_RUN:       if (stop_req_i) state_d = ST_IDLE;
            ST_HOLD_IDLE: state_d = ST_HOLD_IDLE;
            ST_HOLD_RUN:  state_d = ST_HOLD_RUN;
            default:      state_d = ST_IDLE;
        endcase
        // A software write to control takes precedence over a halt
        if (ctl_we_i) state_d = tmr_state_e'(ctl_wdata_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    always_comb begin
        run_o  = 1'b0;
        hold_o = 1'b0;
        unique case (state_q)
            ST_IDLE:      ;
            ST_RUN:       run_o  = 1'b1;
            ST_HOLD_IDLE: hold_o = 1'b1;
            ST_HOLD_RUN:  hold_o = 1'b1;
            default:      ;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/mct_prescaler.sv
module mct_prescaler #(
    parameter int DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              run_i,
    input  logic              hold_i,
    input  logic [DATA_W-1:0] limit_i,
    output logic              tick_o
);

    logic [DATA_W-1:0] pc_q;
    logic              wrap;

    assign wrap   = (pc_q == limit_i);
    assign tick_o = run_i && wrap;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     pc_q <= '0;
        else if (hold_i) pc_q <= '0;
        else if (run_i)  pc_q <= wrap ? '0 : pc_q + 1'b1;
    end

endmodule

// File: rtl/mct_count_match.sv
module mct_count_match
    import mct_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              hold_i,
    input  logic [DATA_W-1:0] cmp_i,
    input  match_act_t        act_i,
    output logic [CNT_W-1:0]  tc_o,
    output logic              match_o
);

    logic [CNT_W-1:0]  tc_q;
    logic [DATA_W-1:0] tc_ext;

    assign tc_ext  = DATA_W'(tc_q);
    assign match_o = tick_i && (tc_ext == cmp_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                      tc_q <= '0;
        else if (hold_i)                  tc_q <= '0;
        else if (tick_i) begin
            if (match_o && act_i.reload)  tc_q <= '0;
            else if (match_o && act_i.halt) tc_q <= tc_q;
            else                          tc_q <= tc_q + 1'b1;
        end
    end

    assign tc_o = tc_q;

endmodule

// File: rtl/mct_timer.sv
module mct_timer
    import mct_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 12,
    parameter int CNT_W  = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o
);

    localparam int ACT_W = $bits(match_act_t);

    logic sel_stat, sel_ctl, sel_cnt, sel_pre, sel_act, sel_cmp, sel_mode;
    assign sel_stat = (addr_i == ADDR_W'(OFS_STAT));
    assign sel_ctl  = (addr_i == ADDR_W'(OFS_CTL));
    assign sel_cnt  = (addr_i == ADDR_W'(OFS_CNT));
    assign sel_pre  = (addr_i == ADDR_W'(OFS_PRE));
    assign sel_act  = (addr_i == ADDR_W'(OFS_ACT));
    assign sel_cmp  = (addr_i == ADDR_W'(OFS_CMP));
    assign sel_mode = (addr_i == ADDR_W'(OFS_MODE));

    logic [DATA_W-1:0] pre_q, cmp_q;
    match_act_t        mcr_q;
    logic              flag_q;

    tmr_state_e        state_w;
    logic              run_w, hold_w, tick_w, match_evt_w;
    logic [CNT_W-1:0]  tc_w;

    mct_ctrl_fsm u_fsm (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .ctl_we_i    (we_i && sel_ctl),
        .ctl_wdata_i (wdata_i[1:0]),
        .stop_req_i  (match_evt_w && mcr_q.halt),
        .state_o     (state_w),
        .run_o       (run_w),
        .hold_o      (hold_w)
    );

    mct_prescaler #(.DATA_W(DATA_W)) u_pre (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .run_i   (run_w),
        .hold_i  (hold_w),
        .limit_i (pre_q),
        .tick_o  (tick_w)
    );

    mct_count_match #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_cnt (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .tick_i  (tick_w),
        .hold_i  (hold_w),
        .cmp_i   (cmp_q),
        .act_i   (mcr_q),
        .tc_o    (tc_w),
        .match_o (match_evt_w)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pre_q <= '0;
            cmp_q <= '0;
            mcr_q <= '0;
        end else if (we_i) begin
            if (sel_pre) pre_q <= wdata_i;
            if (sel_cmp) cmp_q <= wdata_i;
            if (sel_act) mcr_q <= match_act_t'(wdata_i[ACT_W-1:0]);
        end
    end

    // Set from a hit wins over a write-one clear in the same cycle
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                              flag_q <= 1'b0;
        else if (match_evt_w && mcr_q.pend)       flag_q <= 1'b1;
        else if (we_i && sel_stat && wdata_i[0])  flag_q <= 1'b0;
    end

    always_comb begin
        rdata_o = '0;
        if (sel_stat)      rdata_o = DATA_W'(flag_q);
        else if (sel_ctl)  rdata_o = DATA_W'(state_w);
        else if (sel_cnt)  rdata_o = DATA_W'(tc_w);
        else if (sel_pre)  rdata_o = pre_q;
        else if (sel_act)  rdata_o = DATA_W'(mcr_q);
        else if (sel_cmp)  rdata_o = cmp_q;
        else if (sel_mode) rdata_o = '0;
    end

    assign irq_o = flag_q;

endmodule

// File: rtl/mct_timer_chk.sv
module mct_timer_chk
    import mct_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 12,
    parameter int CNT_W  = 32
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [ADDR_W-1:0] addr_i,
    input logic              we_i,
    input logic [DATA_W-1:0] wdata_i,
    input logic              irq_o,
    input logic              tick_w,
    input logic              hold_w,
    input logic              run_w,
    input logic              match_evt_w,
    input match_act_t        mcr_q,
    input logic [CNT_W-1:0]  tc_w
);

    logic ctl_wr, stat_clr;
    assign ctl_wr   = we_i && (addr_i == ADDR_W'(OFS_CTL));
    assign stat_clr = we_i && (addr_i == ADDR_W'(OFS_STAT)) && wdata_i[0];

    // R2: count moves only on a prescaled tick or a hold
    p_count_on_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick_w && !hold_w) |=> $stable(tc_w));

    // R4: a hit with pending action raises the interrupt
    p_hit_raises_irq_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (match_evt_w && mcr_q.pend) |=> irq_o);

    // R5: a hit with count reset yields zero
    p_reload_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (match_evt_w && mcr_q.reload && !hold_w) |=> (tc_w == '0));

    // R6: a hit with halt stops counting unless control is rewritten
    p_halt_stops_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (match_evt_w && mcr_q.halt && !ctl_wr) |=> !run_w);

    // R7: hold forces the count to zero
    p_hold_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hold_w |=> (tc_w == '0));

    // R8: a write-one clear without a simultaneous hit drops the interrupt
    p_w1c_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stat_clr && !(match_evt_w && mcr_q.pend)) |=> !irq_o);

    // R7: hold and run are never both active
    p_hold_run_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(hold_w && run_w));

endmodule

bind mct_timer mct_timer_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .addr_i      (addr_i),
    .we_i        (we_i),
    .wdata_i     (wdata_i),
    .irq_o       (irq_o),
    .tick_w      (tick_w),
    .hold_w      (hold_w),
    .run_w       (run_w),
    .match_evt_w (match_evt_w),
    .mcr_q       (mcr_q),
    .tc_w        (tc_w)
);

// File: tb/mct_timer_tb_top.sv
module mct_timer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 9;

    typedef struct packed {
        logic [31:0] pre;
        logic [31:0] cmp;
        logic [2:0]  act;
        logic [15:0] wait_n;
        logic [31:0] exp_tc;
        logic        exp_flag;
        logic [1:0]  exp_ctl;
    } vec_t;

    // pre, cmp, act, wait, tc, flag, ctl
    localparam vec_t VECS [NVEC] = '{
        '{32'd0, 32'd5,   3'd0, 16'd10, 32'd10, 1'b0, 2'd1},  // R3 hit ignored
        '{32'd3, 32'd0,   3'd0, 16'd20, 32'd5,  1'b0, 2'd1},  // R2 divide by 4
        '{32'd0, 32'd4,   3'd1, 16'd10, 32'd10, 1'b1, 2'd1},  // R4 pend only
        '{32'd0, 32'd4,   3'd3, 16'd12, 32'd2,  1'b1, 2'd1},  // R5 period 5
        '{32'd0, 32'd4,   3'd7, 16'd12, 32'd0,  1'b1, 2'd0},  // R6 one-shot
        '{32'd0, 32'd4,   3'd4, 16'd12, 32'd4,  1'b0, 2'd0},  // R6 halt holds
        '{32'd1, 32'd3,   3'd2, 16'd20, 32'd2,  1'b0, 2'd1},  // R5 with R2
        '{32'd2, 32'd6,   3'd3, 16'd30, 32'd3,  1'b1, 2'd1},  // R5 with R2
        '{32'd0, 32'd100, 3'd1, 16'd50, 32'd50, 1'b0, 2'd1}   // R4 not reached
    };

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [11:0] addr_i = '0;
    logic        we_i = 1'b0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o, rdata_w;
    logic        irq_o, irq_w;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    mct_timer dut_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i),
        .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
    );

    mct_timer #(.CNT_W(8)) dut_w (
        .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i),
        .wdata_i(wdata_i), .rdata_o(rdata_w), .irq_o(irq_w)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk_i);
        addr_i = a; wdata_i = d; we_i = 1'b1;
        @(negedge clk_i);
        we_i = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        addr_i = a;
        #1 d = rdata_o;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [31:0] v, v2;
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);

        // R1: reset state
        rd(12'h000, v); check("R1 stat", v, 0);
        rd(12'h004, v); check("R1 ctl", v, 0);
        rd(12'h008, v); check("R1 cnt", v, 0);
        rd(12'h00C, v); check("R1 pre", v, 0);
        rd(12'h014, v); check("R1 act", v, 0);
        rd(12'h018, v); check("R1 cmp", v, 0);
        check("R1 irq", {31'd0, irq_o}, 0);

        // R10: readback
        wr(12'h00C, 32'h0000_00A5); rd(12'h00C, v); check("R10 pre", v, 32'hA5);
        wr(12'h014, 32'hFFFF_FFFF); rd(12'h014, v); check("R10 act", v, 32'h7);
        wr(12'h018, 32'hDEAD_BEEF); rd(12'h018, v); check("R10 cmp", v, 32'hDEAD_BEEF);
        rd(12'h040, v); check("R10 unmapped", v, 0);

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            wr(12'h004, 32'd2);
            wr(12'h000, 32'd1);
            wr(12'h00C, VECS[i].pre);
            wr(12'h018, VECS[i].cmp);
            wr(12'h014, {29'd0, VECS[i].act});
            wr(12'h004, 32'd1);
            repeat (int'(VECS[i].wait_n)) @(negedge clk_i);
            rd(12'h008, v); check($sformatf("vec%0d cnt R2 R3 R5 R6", i), v, VECS[i].exp_tc);
            rd(12'h000, v); check($sformatf("vec%0d stat R4", i), v, {31'd0, VECS[i].exp_flag});
            check($sformatf("vec%0d irq R4", i), {31'd0, irq_o}, {31'd0, VECS[i].exp_flag});
            rd(12'h004, v); check($sformatf("vec%0d ctl R6", i), v, {30'd0, VECS[i].exp_ctl});
            wr(12'h004, 32'd0);
        end

        // R8: write-one clear
        wr(12'h004, 32'd2); wr(12'h000, 32'd1);
        wr(12'h00C, 32'd0); wr(12'h018, 32'd2); wr(12'h014, 32'd1);
        wr(12'h004, 32'd1);
        repeat (5) @(negedge clk_i);
        wr(12'h004, 32'd0);
        rd(12'h000, v); check("R8 set", v, 1);
        wr(12'h000, 32'd0); rd(12'h000, v); check("R8 write0 keeps", v, 1);
        check("R8 irq kept", {31'd0, irq_o}, 1);
        wr(12'h000, 32'd1); rd(12'h000, v); check("R8 write1 clears", v, 0);
        check("R8 irq cleared", {31'd0, irq_o}, 0);

        // R9: count and mode writes ignored
        rd(12'h008, v);
        wr(12'h008, 32'h0000_1234);
        rd(12'h008, v2); check("R9 cnt write ignored", v2, v);
        wr(12'h070, 32'd5); rd(12'h070, v); check("R9 mode reads 0", v, 0);

        // R7: hold with enable set keeps zero
        wr(12'h014, 32'd0);
        wr(12'h004, 32'd3);
        repeat (10) @(negedge clk_i);
        rd(12'h008, v); check("R7 held cnt", v, 0);
        rd(12'h004, v); check("R7 ctl reads 3", v, 3);
        wr(12'h004, 32'd1);
        repeat (3) @(negedge clk_i);
        rd(12'h008, v); check("R7 release counts", v, 3);

        // R6: restart after one-shot
        wr(12'h004, 32'd2); wr(12'h000, 32'd1);
        wr(12'h018, 32'd4); wr(12'h014, 32'd7);
        wr(12'h004, 32'd1);
        repeat (8) @(negedge clk_i);
        rd(12'h008, v); check("R6 shot cnt", v, 0);
        rd(12'h004, v); check("R6 shot ctl", v, 0);
        wr(12'h000, 32'd1);
        wr(12'h004, 32'd1);
        repeat (3) @(negedge clk_i);
        rd(12'h008, v); check("R6 restart cnt", v, 3);
        rd(12'h004, v); check("R6 restart ctl", v, 1);
        rd(12'h000, v); check("R6 restart no flag", v, 0);

        // R3: wrap at counter width (8-bit instance)
        wr(12'h004, 32'd2); wr(12'h014, 32'd0); wr(12'h00C, 32'd0);
        wr(12'h004, 32'd1);
        repeat (260) @(negedge clk_i);
        addr_i = 12'h008;
        #1;
        check("R3 wrap narrow", rdata_w, 32'd4);
        check("R3 wide no wrap", rdata_o, 32'd260);

        finish_run();
    end

endmodule